// File: doc/BRIEF.md
# Flyback Protection Fault Qualification Sequencer

This block supervises a primary-side regulated flyback controller once per switching cycle. Comparator results that have already been digitised arrive with a cycle strobe. Each fault kind is then qualified by its own rule: consecutive cycles, a start-up window, a check on the first cycle only, an immediate trip, or a continuous millisecond timer. When a fault qualifies, the block stops switching. It keeps the bias at its high (run) level so that VDD discharges to the turn-off level. It then waits for the next VDD turn-on before switching again.

A soft-short latch covers an output that sits below its undervoltage level in constant-current mode. When the latch is set, the block lets several VDD power-ups go by with no switching before it resumes normal operation. The controller uses the outputs to gate the PWM, to hold the peak current at its minimum during start-up, to pick the bias level, and to report which fault fired.

Top module: `prot_qual_seq`

## Requirements
- R1: After reset the block is idle. `sw_en`=0, `min_ipp`=0, `bias_hi`=0 and `fault_code`=0 (none). It stays idle until a `vdd_on_evt` pulse arrives.
- R2: A `vdd_on_evt` while idle sets `sw_en`=1 and `bias_hi`=1 and clears `fault_code` to 0 on the next clock. `min_ipp` stays 1 until three `cyc_strobe` pulses have occurred, and is 0 after that.
- R3: `ovp_flag` set on three consecutive strobes stops switching with `fault_code`=1. A strobe without the flag resets the run of consecutive cycles to zero.
- R4: `ocp_flag` set on three consecutive strobes stops switching with `fault_code`=2. A strobe without the flag resets that count. When several faults qualify on the same strobe, the lower code wins among codes 1, 2, 4, 6 and 8. Code 7 has priority over code 5, code 5 over code 3, and code 3 over code 1.
- R5: If `line_run_flag` has not been seen on any of the first three strobes after power-up, the third strobe stops switching with `fault_code`=3.
- R6: After `line_run_flag` has been seen, `line_stop_flag` set on three consecutive strobes stops switching with `fault_code`=4.
- R7: On the first strobe after power-up only, `cs_reach_flag`=0 stops switching at once with `fault_code`=5. On later strobes `cs_reach_flag` has no effect.
- R8: `ntc_low_flag` set on three consecutive strobes stops switching with `fault_code`=6.
- R9: `otp_flag` high on any clock while switching stops switching on the next clock with `fault_code`=7.
- R10: After a fault, `bias_hi` stays 1 and `vdd_on_evt` is ignored until `vdd_off_evt`. After `vdd_off_evt`, `bias_hi`=0. `fault_code` holds its value until the next `vdd_on_evt` while idle.
- R11: While switching, if `cc_mode` and `ccuv_flag` are both held high for `CCUV_MS` (default 120) `ms_tick` pulses, switching stops with `fault_code`=8 and the soft-short latch is set. Any clock on which that condition drops resets the timer.
- R12: While the soft-short latch is set, each of the next three power-ups gives `sw_en`=0, `bias_hi`=1 and `fault_code`=8 until `vdd_off_evt`. The fourth power-up clears the latch and switches normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_strobe | input | 1 | One-clock pulse at the end of a switching cycle; the per-cycle flags are valid with it |
| ovp_flag | input | 1 | Output voltage sample above the over-voltage level |
| ocp_flag | input | 1 | Primary over-current seen inside the valid window |
| line_run_flag | input | 1 | Line sense current above the run threshold |
| line_stop_flag | input | 1 | Line sense current below the stop threshold |
| ntc_low_flag | input | 1 | Thermistor pin below threshold at the end of demagnetisation |
| otp_flag | input | 1 | Internal over-temperature, level-sensitive |
| cs_reach_flag | input | 1 | Current sense reached its minimum within the check window this cycle |
| ccuv_flag | input | 1 | Voltage sense below the constant-current undervoltage level |
| cc_mode | input | 1 | Loop is in constant-current regulation |
| vdd_on_evt | input | 1 | Pulse: VDD crossed the turn-on threshold |
| vdd_off_evt | input | 1 | Pulse: VDD fell to the turn-off threshold |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| sw_en | output | 1 | Switching enable |
| min_ipp | output | 1 | Limit peak current to its minimum |
| bias_hi | output | 1 | 1 selects the run bias level, 0 the low standby level |
| fault_code | output | 4 | Last qualified fault (0 none, 1..8 as in the requirements) |

## Verification
On every cycle, the assertions check the following invariants. Each qualification counter returns to zero after a cycle that lacks its flag. No counter or timer passes its limit. `sw_en` never drops without a nonzero fault code, except when VDD turns off. `min_ipp` and `sw_en` imply the run bias. A latched fault code stays stable until a power-up.

Only the directed scenarios can show the rest. These cover which code each fault produces, and the exact strobe on which it trips. They cover how an interrupted streak defers a trip, and that the current-sense check is ignored after the first cycle. They also cover the 120-tick timer restart and the three blocked power-ups before recovery.

// File: rtl/prot_pkg.sv
// Shared types for the protection sequencer.
// Assumes: fault codes fit in four bits; state encoding is free.
package prot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2,
        ST_BLOCK = 2'd3
    } seq_state_e;

    typedef enum logic [3:0] {
        FC_NONE  = 4'd0,
        FC_OVP   = 4'd1,
        FC_OCP   = 4'd2,
        FC_LSTRT = 4'd3,
        FC_LSTOP = 4'd4,
        FC_CSGND = 4'd5,
        FC_NTC   = 4'd6,
        FC_OTP   = 4'd7,
        FC_CCUV  = 4'd8
    } fault_code_e;
endpackage

// File: rtl/consec_qual.sv
// Consecutive-cycle qualifier: trips when the flag is present on NCONSEC
// strobes in a row. Assumes the flag is only meaningful while strobe is high;
// clr holds the count at zero while the converter is not switching.
module consec_qual #(
    parameter int NCONSEC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic strobe,
    input  logic flag,
    output logic trip
);
    localparam int CW = $clog2(NCONSEC + 1);
    localparam logic [CW-1:0] LAST = CW'(NCONSEC - 1);

    logic [CW-1:0] cnt;

    // Combinational trip on the strobe that completes the streak.
    assign trip = !clr && strobe && flag && (cnt == LAST);

    // Count streak length; any strobe without the flag restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (strobe) begin
            if (!flag)
                cnt <= '0;
            else if (cnt != LAST)
                cnt <= cnt + 1'b1;
        end
    end

    p_clear_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !flag && !clr) |=> (cnt == '0));
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/softshort_guard.sv
// Soft-short guard: a millisecond timer that requires the undervoltage-in-CC
// condition to hold without a break, plus a latch that blocks SKIP_PWRUP
// power-ups before clearing on the next one. Assumes pwrup pulses once per
// VDD turn-on accepted by the sequencer.
module softshort_guard #(
    parameter int CCUV_MS    = 120,
    parameter int SKIP_PWRUP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic cond,
    input  logic tick,
    input  logic pwrup,
    output logic trip,
    output logic block
);
    localparam int TW = $clog2(CCUV_MS + 1);
    localparam int UW = $clog2(SKIP_PWRUP + 1);
    localparam logic [TW-1:0] TLAST = TW'(CCUV_MS - 1);
    localparam logic [UW-1:0] ULAST = UW'(SKIP_PWRUP);

    logic [TW-1:0] tcnt;
    logic [UW-1:0] ucnt;
    logic          latched;

    assign trip  = running && cond && tick && (tcnt == TLAST);
    assign block = latched && (ucnt != ULAST);

    // Continuous-duration timer, cleared whenever the condition lapses.
    always_ff @(posedge clk) begin
        if (!rst_n || !running || !cond)
            tcnt <= '0;
        else if (tick && tcnt != TLAST)
            tcnt <= tcnt + 1'b1;
    end

    // Latch and its power-up counter; released on the power-up after the skips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched <= 1'b0;
            ucnt    <= '0;
        end else if (trip) begin
            latched <= 1'b1;
            ucnt    <= '0;
        end else if (pwrup && latched) begin
            if (ucnt == ULAST) begin
                latched <= 1'b0;
                ucnt    <= '0;
            end else begin
                ucnt <= ucnt + 1'b1;
            end
        end
    end

    p_timer_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt <= TLAST);
    p_skip_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ucnt <= ULAST);
endmodule

// File: rtl/prot_qual_seq.sv
// Protection fault qualification sequencer (top).
// Qualifies per-cycle fault flags, runs the stop/discharge/restart sequence
// and drives switching enable, minimum-peak limit, bias select and fault code.
// Assumes event inputs are single-clock pulses already synchronised to clk.
module prot_qual_seq
    import prot_pkg::*;
#(
    parameter int NCONSEC    = 3,
    parameter int START_CYC  = 3,
    parameter int CCUV_MS    = 120,
    parameter int SKIP_PWRUP = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_strobe,
    input  logic       ovp_flag,
    input  logic       ocp_flag,
    input  logic       line_run_flag,
    input  logic       line_stop_flag,
    input  logic       ntc_low_flag,
    input  logic       otp_flag,
    input  logic       cs_reach_flag,
    input  logic       ccuv_flag,
    input  logic       cc_mode,
    input  logic       vdd_on_evt,
    input  logic       vdd_off_evt,
    input  logic       ms_tick,
    output logic       sw_en,
    output logic       min_ipp,
    output logic [3:0] fault_code
    ,output logic      bias_hi
);
    localparam int NQ = 4;
    localparam int SW = $clog2(START_CYC + 1);
    localparam logic [SW-1:0] SLAST = SW'(START_CYC);

    seq_state_e    state;
    fault_code_e   code_q;
    fault_code_e   trip_code;
    logic [SW-1:0] cyc_cnt;
    logic          run_met;
    logic          running;
    logic          pwrup;
    logic          cs_fail;
    logic          start_fail;
    logic          ss_trip;
    logic          ss_block;
    logic [NQ-1:0] qflag;
    logic [NQ-1:0] qtrip;

    assign running = (state == ST_RUN);
    assign pwrup   = (state == ST_IDLE) && vdd_on_evt;

    // Flags qualified by consecutive strobes: ovp, ocp, line stop, thermistor.
    assign qflag = {ntc_low_flag, line_stop_flag && run_met, ocp_flag, ovp_flag};

    generate
        for (genvar i = 0; i < NQ; i++) begin : g_qual
            consec_qual #(.NCONSEC(NCONSEC)) u_q (
                .clk(clk), .rst_n(rst_n), .clr(!running),
                .strobe(cyc_strobe), .flag(qflag[i]), .trip(qtrip[i])
            );
        end
    endgenerate

    softshort_guard #(.CCUV_MS(CCUV_MS), .SKIP_PWRUP(SKIP_PWRUP)) u_ss (
        .clk(clk), .rst_n(rst_n), .running(running),
        .cond(cc_mode && ccuv_flag), .tick(ms_tick), .pwrup(pwrup),
        .trip(ss_trip), .block(ss_block)
    );

    // Start-window checks: current-sense reach on cycle one, line run by cycle three.
    assign cs_fail    = running && cyc_strobe && (cyc_cnt == '0) && !cs_reach_flag;
    assign start_fail = running && cyc_strobe && (cyc_cnt == SW'(START_CYC - 1))
                        && !run_met && !line_run_flag;

    // Pick the winning fault for this clock by fixed priority.
    always_comb begin
        if (running && otp_flag)  trip_code = FC_OTP;
        else if (cs_fail)         trip_code = FC_CSGND;
        else if (start_fail)      trip_code = FC_LSTRT;
        else if (qtrip[0])        trip_code = FC_OVP;
        else if (qtrip[1])        trip_code = FC_OCP;
        else if (qtrip[2])        trip_code = FC_LSTOP;
        else if (qtrip[3])        trip_code = FC_NTC;
        else if (ss_trip)         trip_code = FC_CCUV;
        else                      trip_code = FC_NONE;
    end

    // Sequencer: idle -> run -> fault/blocked -> idle on VDD turn-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            code_q  <= FC_NONE;
            cyc_cnt <= '0;
            run_met <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (vdd_on_evt) begin
                    state   <= ss_block ? ST_BLOCK : ST_RUN;
                    code_q  <= ss_block ? FC_CCUV : FC_NONE;
                    cyc_cnt <= '0;
                    run_met <= 1'b0;
                end
                ST_RUN: begin
                    if (trip_code != FC_NONE) begin
                        state  <= ST_FAULT;
                        code_q <= trip_code;
                    end else if (vdd_off_evt) begin
                        state <= ST_IDLE;
                    end else if (cyc_strobe) begin
                        if (cyc_cnt != SLAST) cyc_cnt <= cyc_cnt + 1'b1;
                        if (line_run_flag)    run_met <= 1'b1;
                    end
                end
                default: if (vdd_off_evt) state <= ST_IDLE;
            endcase
        end
    end

    assign sw_en      = running;
    assign bias_hi    = (state != ST_IDLE);
    assign min_ipp    = running && (cyc_cnt != SLAST);
    assign fault_code = code_q;

    p_stop_has_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_en) && !$past(vdd_off_evt)) |-> (fault_code != 4'd0));
    p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 4'd0 && !vdd_on_evt) |=> $stable(fault_code));
    p_minipp_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        min_ipp |-> sw_en);
    p_run_bias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> bias_hi);
endmodule

// File: tb/prot_qual_seq_tb.sv
module prot_qual_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 0, ovp = 0, ocp = 0, lrun = 0, lstop = 0, ntc = 0, otp = 0, csok = 0;
    logic ccuv = 0, ccm = 0, von = 0, voff = 0, tick = 0;
    logic sw_en, min_ipp, bias_hi;
    logic [3:0] fault_code;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prot_qual_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(strobe), .ovp_flag(ovp), .ocp_flag(ocp),
        .line_run_flag(lrun), .line_stop_flag(lstop), .ntc_low_flag(ntc), .otp_flag(otp),
        .cs_reach_flag(csok), .ccuv_flag(ccuv), .cc_mode(ccm), .vdd_on_evt(von),
        .vdd_off_evt(voff), .ms_tick(tick), .sw_en(sw_en), .min_ipp(min_ipp),
        .fault_code(fault_code), .bias_hi(bias_hi)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_on();
        @(negedge clk) von = 1; @(negedge clk) von = 0;
    endtask
    task automatic pulse_off();
        @(negedge clk) voff = 1; @(negedge clk) voff = 0;
    endtask
    task automatic restart();
        pulse_off(); pulse_on();
    endtask

    // One switching cycle: o=ovp c=ocp r=line run s=line stop n=ntc k=cs reached.
    task automatic cyc(input logic o, c, r, s, n, k);
        @(negedge clk) begin ovp = o; ocp = c; lrun = r; lstop = s; ntc = n; csok = k; strobe = 1; end
        @(negedge clk) begin strobe = 0; ovp = 0; ocp = 0; lrun = 0; lstop = 0; ntc = 0; csok = 0; end
    endtask
    task automatic good();
        cyc(0, 0, 1, 0, 0, 1);
    endtask

    task automatic t_reset();
        chk("R1 sw_en", sw_en, 0); chk("R1 bias", bias_hi, 0);
        chk("R1 code", fault_code, 0); chk("R1 min_ipp", min_ipp, 0);
    endtask

    task automatic t_startup();
        pulse_on();
        chk("R2 sw_en", sw_en, 1); chk("R2 bias", bias_hi, 1); chk("R2 min_ipp", min_ipp, 1);
        good(); good();
        chk("R2 min_ipp after 2", min_ipp, 1);
        good();
        chk("R2 min_ipp after 3", min_ipp, 0);
    endtask

    task automatic t_ovp();
        restart(); good(); good(); good();
        cyc(1, 0, 0, 0, 0, 1); cyc(1, 0, 0, 0, 0, 1); good();
        cyc(1, 0, 0, 0, 0, 1); cyc(1, 0, 0, 0, 0, 1);
        chk("R3 streak broken", sw_en, 1);
        cyc(1, 0, 0, 0, 0, 1);
        chk("R3 sw_en", sw_en, 0); chk("R3 code", fault_code, 1);
        // R10 behaviour after fault
        chk("R10 bias held", bias_hi, 1);
        pulse_on();
        chk("R10 on ignored", sw_en, 0); chk("R10 code held", fault_code, 1);
        pulse_off();
        chk("R10 bias low", bias_hi, 0); chk("R10 code kept", fault_code, 1);
        pulse_on();
        chk("R10 code cleared", fault_code, 0); chk("R10 running", sw_en, 1);
    endtask

    task automatic t_ocp();
        restart(); good(); good(); good();
        cyc(0, 1, 0, 0, 0, 1); cyc(0, 1, 0, 0, 0, 1); good();
        cyc(0, 1, 0, 0, 0, 1); cyc(0, 1, 0, 0, 0, 1);
        chk("R4 streak broken", sw_en, 1);
        cyc(0, 1, 0, 0, 0, 1);
        chk("R4 code", fault_code, 2);
        restart(); good(); good(); good();
        repeat (3) cyc(1, 1, 0, 0, 0, 1);
        chk("R4 priority ovp over ocp", fault_code, 1);
    endtask

    task automatic t_line_start();
        restart();
        cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 1);
        chk("R5 still running", sw_en, 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R5 code", fault_code, 3); chk("R5 sw_en", sw_en, 0);
        restart();
        cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 1, 0, 0, 1);
        chk("R5 met on third", sw_en, 1);
    endtask

    task automatic t_line_stop();
        restart(); good(); good(); good();
        cyc(0, 0, 0, 1, 0, 1); cyc(0, 0, 0, 1, 0, 1); good();
        cyc(0, 0, 0, 1, 0, 1); cyc(0, 0, 0, 1, 0, 1);
        chk("R6 streak broken", sw_en, 1);
        cyc(0, 0, 0, 1, 0, 1);
        chk("R6 code", fault_code, 4);
    endtask

    task automatic t_cs();
        restart();
        cyc(0, 0, 1, 0, 0, 0);
        chk("R7 first cycle code", fault_code, 5); chk("R7 sw_en", sw_en, 0);
        restart(); good();
        cyc(0, 0, 1, 0, 0, 0); cyc(0, 0, 1, 0, 0, 0); cyc(0, 0, 1, 0, 0, 0);
        chk("R7 later ignored", sw_en, 1); chk("R7 later code", fault_code, 0);
    endtask

    task automatic t_ntc();
        restart(); good(); good(); good();
        cyc(0, 0, 0, 0, 1, 1); cyc(0, 0, 0, 0, 1, 1);
        chk("R8 two cycles", sw_en, 1);
        cyc(0, 0, 0, 0, 1, 1);
        chk("R8 code", fault_code, 6);
    endtask

    task automatic t_otp();
        restart(); good();
        @(negedge clk) otp = 1;
        @(negedge clk) otp = 0;
        chk("R9 code", fault_code, 7); chk("R9 sw_en", sw_en, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1; @(negedge clk) tick = 0;
        end
    endtask

    task automatic t_ccuv();
        restart(); good(); good(); good();
        ccm = 1; ccuv = 1;
        ticks(119);
        chk("R11 119 ticks", sw_en, 1);
        @(negedge clk) ccuv = 0; @(negedge clk) ccuv = 1;
        ticks(119);
        chk("R11 timer restarted", sw_en, 1);
        ticks(1);
        chk("R11 code", fault_code, 8); chk("R11 sw_en", sw_en, 0);
        ccm = 0; ccuv = 0;
    endtask

    task automatic t_latch();
        for (int k = 1; k <= 3; k++) begin
            restart();
            chk("R12 blocked sw_en", sw_en, 0); chk("R12 blocked bias", bias_hi, 1);
            chk("R12 blocked code", fault_code, 8);
        end
        restart();
        chk("R12 fourth runs", sw_en, 1); chk("R12 fourth code", fault_code, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_startup(); t_ovp(); t_ocp(); t_line_start(); t_line_stop();
        t_cs(); t_ntc(); t_otp(); t_ccuv(); t_latch();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule